// File: doc/BRIEF.md
# Pipelined Signed Multiplier with Two-Bit Partial-Product Rows

This block multiplies two signed two's-complement operands whose widths are set by parameters. It returns the full-precision signed product, as wide as the two operand widths added together. The narrower operand is split into two-bit digits. Each digit picks a partial product of the wider operand, and each pipeline row adds one such term into a running sum, shifted into place. When the first operand is the wider one, the block swaps the two internally, so the digit count, and with it the pipeline depth, always follows the narrower width.

A single clock enable moves the whole pipeline forward. When the enable is low, every register keeps its value. A product appears at the output a fixed number of enabled cycles after its operands were taken in. All pipeline registers power up at zero, so the output reads zero until the first real product arrives. The narrower width must be at least 5 bits. The wider width has no limit.

Top module: `smul_top`

## Requirements
- R1: `prod` equals the signed product of `op_a` and `op_b`, taken as two's-complement numbers. It is exact and A_W+B_W bits wide.
- R2: Let N be the smaller of A_W and B_W. There are ceil(N/2) rows. A pair of operands sampled on one enabled rising edge shows up on `prod` just after the ceil(N/2)+2-th enabled edge, counting the sampling edge as the first.
- R3: On an edge where `ce` is low, no register changes, so `prod` keeps its previous value.
- R4: The block gives the same product with the same latency whichever operand port carries the wider value. If A_W > B_W, the operands are swapped internally.
- R5: If either operand is zero, the product is zero.
- R6: If one operand is +1, the product is the other operand sign-extended to A_W+B_W bits.
- R7: If one operand is all ones (−1), the product is the two's-complement negation of the other operand, sign-extended.
- R8: An odd narrower width is padded by sign extension to an even number of bits. The top digit counts as a signed value from −2 to +1, so the top bit carries negative weight.
- R9: From power-up, `prod` is zero until the first enabled pair has passed through every stage.
- R10: Extreme operands give exact results: the most negative value times the most negative value, the most negative value times the most positive value, and the most positive value times itself.
- R11: If both operands are nonzero, the sign bit of the product is the XOR of the two operand sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Clock enable. The pipeline moves only while this is high |
| op_a | input | A_W | First signed operand |
| op_b | input | B_W | Second signed operand |
| prod | output | A_W+B_W | Registered signed product |

## Verification
The properties look at the last row stage. They assume that the digit operand, the wide operand and the accumulated sum held there all come from one operand pair, which holds only if `ce` is the only thing that moves the pipeline. They also assume the narrower width is at least 5 bits, so the sign-extended digit operand is never all ones and equal to +1 at once. The stimulus lets `ce` toggle freely, including long low stretches. It keeps every instance at a narrower width of 7 or 8, and it holds the operands steady between falling and rising edges, so each enabled edge captures exactly one well-defined pair.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Partial-product choice for one two-bit digit of the narrow operand
  typedef enum logic [2:0] {
    PP_ZERO    = 3'd0,
    PP_ONE     = 3'd1,
    PP_TWO     = 3'd2,
    PP_THREE   = 3'd3,
    PP_NEG_TWO = 3'd4,
    PP_NEG_ONE = 3'd5
  } pp_sel_e;

  localparam int DIGIT_BITS = 2;

  // Number of digit rows for a narrow operand of width w
  function automatic int row_count(input int w);
    return (w + DIGIT_BITS - 1) / DIGIT_BITS;
  endfunction

  // Lower digits are unsigned (0..3); the top digit is signed (-2..1)
  function automatic pp_sel_e digit_decode(input logic [1:0] d, input logic top_row);
    pp_sel_e s;
    unique case (d)
      2'd0: s = PP_ZERO;
      2'd1: s = PP_ONE;
      2'd2: s = top_row ? PP_NEG_TWO : PP_TWO;
      default: s = top_row ? PP_NEG_ONE : PP_THREE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/smul_order.sv
module smul_order #(
  parameter int A_W = 8,
  parameter int B_W = 12,
  localparam int NW = (A_W < B_W) ? A_W : B_W,
  localparam int WW = (A_W < B_W) ? B_W : A_W
) (
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic [NW-1:0]  nar,
  output logic [WW-1:0]  wid
);

  generate
    if (A_W <= B_W) begin : g_keep
      assign nar = op_a;
      assign wid = op_b;
    end else begin : g_swap
      assign nar = op_b;
      assign wid = op_a;
    end
  endgenerate

endmodule

// File: rtl/smul_row.sv
module smul_row
  import smul_pkg::*;
#(
  parameter int NW  = 8,
  parameter int WW  = 12,
  parameter int PW  = 8,
  parameter int K   = 0,
  parameter bit TOP = 1'b0,
  localparam int OW = NW + WW,
  localparam int SH = 2 * K
) (
  input  logic          clk,
  input  logic          ce,
  input  logic [PW-1:0] a_in,
  input  logic [WW-1:0] b_in,
  input  logic [OW-1:0] acc_in,
  output logic [PW-1:0] a_out,
  output logic [WW-1:0] b_out,
  output logic [OW-1:0] acc_out
);

  // Shift-and-add selection of the partial product
  function automatic logic [OW-1:0] pick(input pp_sel_e s, input logic [OW-1:0] b);
    logic [OW-1:0] r;
    unique case (s)
      PP_ONE:     r = b;
      PP_TWO:     r = b << 1;
      PP_THREE:   r = b + (b << 1);
      PP_NEG_TWO: r = '0 - (b << 1);
      PP_NEG_ONE: r = '0 - b;
      default:    r = '0;
    endcase
    return r;
  endfunction

  logic [1:0]    digit;
  pp_sel_e       sel;
  logic [OW-1:0] b_ext;
  logic [OW-1:0] row_pp;
  logic [OW-1:0] row_term;

  assign digit    = a_in[SH+1:SH];
  assign sel      = digit_decode(digit, TOP);
  assign b_ext    = OW'($signed(b_in));
  assign row_pp   = pick(sel, b_ext);
  assign row_term = row_pp << SH;

  logic [PW-1:0] a_q   = '0;
  logic [WW-1:0] b_q   = '0;
  logic [OW-1:0] acc_q = '0;

  always_ff @(posedge clk) begin
    if (ce) begin
      a_q   <= a_in;
      b_q   <= b_in;
      acc_q <= acc_in + row_term;
    end
  end

  assign a_out   = a_q;
  assign b_out   = b_q;
  assign acc_out = acc_q;

endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 12
) (
  input  logic               clk,
  input  logic               ce,
  input  logic [A_W-1:0]     op_a,
  input  logic [B_W-1:0]     op_b,
  output logic [A_W+B_W-1:0] prod
);

  localparam int NW   = (A_W < B_W) ? A_W : B_W;
  localparam int WW   = (A_W < B_W) ? B_W : A_W;
  localparam int OW   = A_W + B_W;
  localparam int ROWS = row_count(NW);
  localparam int PW   = 2 * ROWS;

  logic [NW-1:0] nar_w;
  logic [WW-1:0] wid_w;

  smul_order #(.A_W(A_W), .B_W(B_W)) u_order (
    .op_a (op_a),
    .op_b (op_b),
    .nar  (nar_w),
    .wid  (wid_w)
  );

  // Input stage: narrow operand sign-extended to an even width
  logic [PW-1:0] s0_a = '0;
  logic [WW-1:0] s0_b = '0;

  always_ff @(posedge clk) begin
    if (ce) begin
      s0_a <= PW'($signed(nar_w));
      s0_b <= wid_w;
    end
  end

  logic [PW-1:0] a_c   [0:ROWS];
  logic [WW-1:0] b_c   [0:ROWS];
  logic [OW-1:0] acc_c [0:ROWS];

  assign a_c[0]   = s0_a;
  assign b_c[0]   = s0_b;
  assign acc_c[0] = '0;

  generate
    for (genvar k = 0; k < ROWS; k++) begin : g_row
      smul_row #(
        .NW(NW), .WW(WW), .PW(PW), .K(k), .TOP(k == ROWS - 1)
      ) u_row (
        .clk     (clk),
        .ce      (ce),
        .a_in    (a_c[k]),
        .b_in    (b_c[k]),
        .acc_in  (acc_c[k]),
        .a_out   (a_c[k+1]),
        .b_out   (b_c[k+1]),
        .acc_out (acc_c[k+1])
      );
    end
  endgenerate

  // Named last-stage signals for the checker
  logic [PW-1:0] a_last;
  logic [WW-1:0] b_last;
  logic [OW-1:0] acc_last;

  assign a_last   = a_c[ROWS];
  assign b_last   = b_c[ROWS];
  assign acc_last = acc_c[ROWS];

  logic [OW-1:0] prod_q = '0;

  always_ff @(posedge clk) begin
    if (ce) prod_q <= acc_last;
  end

  assign prod = prod_q;

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int PW = 8,
  parameter int WW = 12,
  parameter int OW = 20
) (
  input logic          clk,
  input logic          ce,
  input logic [PW-1:0] a_last,
  input logic [WW-1:0] b_last,
  input logic [OW-1:0] acc_last,
  input logic [OW-1:0] prod
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  logic [OW-1:0] b_sx;
  logic [OW-1:0] a_sx;
  assign b_sx = OW'($signed(b_last));
  assign a_sx = OW'($signed(a_last));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!past_ok)
    !ce |=> $stable(prod));

  // R2
  out_follows_sum_chk: assert property (@(posedge clk) disable iff (!past_ok)
    ce |=> prod == $past(acc_last));

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (!past_ok)
    (a_last == '0 || b_last == '0) |-> acc_last == '0);

  // R6
  unit_operand_chk: assert property (@(posedge clk) disable iff (!past_ok)
    (a_last == PW'(1)) |-> acc_last == b_sx);

  // R6
  unit_wide_chk: assert property (@(posedge clk) disable iff (!past_ok)
    (b_last == WW'(1)) |-> acc_last == a_sx);

  // R7
  minus_one_chk: assert property (@(posedge clk) disable iff (!past_ok)
    (&a_last) |-> acc_last == ('0 - b_sx));

  // R11
  sign_xor_chk: assert property (@(posedge clk) disable iff (!past_ok)
    (a_last != '0 && b_last != '0) |-> acc_last[OW-1] == (a_last[PW-1] ^ b_last[WW-1]));

endmodule

bind smul_top smul_chk #(.PW(PW), .WW(WW), .OW(OW)) u_chk (
  .clk      (clk),
  .ce       (ce),
  .a_last   (a_last),
  .b_last   (b_last),
  .acc_last (acc_last),
  .prod     (prod)
);

// File: tb/smul_top_bench.sv
`timescale 1ns/1ps
module smul_top_bench;

  localparam int LAT0 = (8 + 1) / 2 + 2;  // 8x12 and 12x8
  localparam int LAT2 = (7 + 1) / 2 + 2;  // 9x7, odd narrow side

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        ce = 1'b0;
  logic [7:0]  a8 = '0;
  logic [11:0] b12 = '0;
  logic [8:0]  c9 = '0;
  logic [6:0]  d7 = '0;
  logic [19:0] p0, p1;
  logic [15:0] p2;

  smul_top #(.A_W(8), .B_W(12)) u_smul_top (
    .clk(clk), .ce(ce), .op_a(a8), .op_b(b12), .prod(p0));
  smul_top #(.A_W(12), .B_W(8)) u_swap (
    .clk(clk), .ce(ce), .op_a(b12), .op_b(a8), .prod(p1));
  smul_top #(.A_W(9), .B_W(7)) u_odd (
    .clk(clk), .ce(ce), .op_a(c9), .op_b(d7), .prod(p2));

  logic [19:0] m0 [0:LAT0-1];
  logic [15:0] m2 [0:LAT2-1];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, update the model on the rising edge, compare after it
  task automatic step(input logic [7:0] a, input logic [11:0] b,
                      input logic [8:0] c, input logic [6:0] d,
                      input logic e, input string tag);
    @(negedge clk);
    a8 = a; b12 = b; c9 = c; d7 = d; ce = e;
    @(posedge clk);
    if (e) begin
      for (int i = LAT0 - 1; i > 0; i--) m0[i] = m0[i-1];
      m0[0] = $signed(a) * $signed(b);
      for (int i = LAT2 - 1; i > 0; i--) m2[i] = m2[i-1];
      m2[0] = $signed(c) * $signed(d);
    end
    #1;
    chk({tag, " 8x12"}, 32'(p0), 32'(m0[LAT0-1]));
    chk({tag, " R4 12x8"}, 32'(p1), 32'(m0[LAT0-1]));
    chk({tag, " 9x7"}, 32'(p2), 32'(m2[LAT2-1]));
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < LAT0 + 1; i++) step('0, '0, '0, '0, 1'b1, tag);
  endtask

  // R9: zero at power-up and until the first pair has drained through
  task automatic t_powerup();
    #1;
    chk("R9 initial", 32'(p0), 32'd0);
    chk("R9 initial odd", 32'(p2), 32'd0);
    for (int i = 0; i < LAT0 - 1; i++) begin
      step(8'd37, 12'd1000, 9'd200, 7'd50, 1'b1, "R9");
      chk("R9 still zero", 32'(p0), 32'd0);
    end
    flush("R9");
  endtask

  // R2: count enabled edges until a lone pair appears
  task automatic t_latency();
    int n;
    flush("R2");
    step(8'd3, 12'd5, 9'd3, 7'd5, 1'b1, "R2");
    n = 1;
    while (p0 == 20'd0 && n < 20) begin
      step('0, '0, '0, '0, 1'b1, "R2");
      n++;
    end
    chk("R2 latency", 32'(n), 32'(LAT0));
    chk("R2 value", 32'(p0), 32'd15);
  endtask

  // R3: enable low freezes the output
  task automatic t_hold();
    logic [19:0] held;
    step(8'h81, 12'h7FF, 9'h101, 7'h41, 1'b1, "R3");
    for (int i = 0; i < LAT0; i++) step(8'h00, 12'h000, 9'd0, 7'd0, 1'b1, "R3");
    held = p0;
    for (int i = 0; i < 5; i++) begin
      step(8'h55, 12'h333, 9'h0AA, 7'h2A, 1'b0, "R3");
      chk("R3 frozen", 32'(p0), 32'(held));
    end
    flush("R3");
  endtask

  task automatic t_zero();   // R5
    step(8'h00, 12'h9AB, 9'h000, 7'h55, 1'b1, "R5");
    step(8'hC3, 12'h000, 9'h1FF, 7'h00, 1'b1, "R5");
    step(8'h80, 12'h000, 9'h100, 7'h00, 1'b1, "R5");
    flush("R5");
  endtask

  task automatic t_one();    // R6
    step(8'h01, 12'h8F3, 9'h001, 7'h47, 1'b1, "R6");
    step(8'hA7, 12'h001, 9'h18C, 7'h01, 1'b1, "R6");
    flush("R6");
  endtask

  task automatic t_minus_one();  // R7
    step(8'hFF, 12'h123, 9'h1FF, 7'h3A, 1'b1, "R7");
    step(8'h5C, 12'hFFF, 9'h0F1, 7'h7F, 1'b1, "R7");
    step(8'hFF, 12'h800, 9'h100, 7'h7F, 1'b1, "R7");
    flush("R7");
  endtask

  task automatic t_extremes();  // R10
    step(8'h80, 12'h800, 9'h100, 7'h40, 1'b1, "R10");
    step(8'h80, 12'h7FF, 9'h100, 7'h3F, 1'b1, "R10");
    step(8'h7F, 12'h7FF, 9'h0FF, 7'h3F, 1'b1, "R10");
    step(8'h7F, 12'h800, 9'h0FF, 7'h40, 1'b1, "R10");
    flush("R10");
    chk("R10 min*min", 32'($signed(8'h80) * $signed(12'h800)), 32'(20'h40000));
  endtask

  // R8: odd narrow width with the top bit set
  task automatic t_odd();
    step('0, '0, 9'h0C5, 7'h41, 1'b1, "R8");
    step('0, '0, 9'h133, 7'h60, 1'b1, "R8");
    step('0, '0, 9'h07E, 7'h7E, 1'b1, "R8");
    flush("R8");
  endtask

  // R1 R4 R11: random operands with randomly gated enable
  task automatic t_random();
    for (int i = 0; i < 400; i++)
      step(8'($urandom), 12'($urandom), 9'($urandom), 7'($urandom),
           1'($urandom % 3 != 0), "R1 R11");
    flush("R1");
  endtask

  initial begin
    for (int i = 0; i < LAT0; i++) m0[i] = '0;
    for (int i = 0; i < LAT2; i++) m2[i] = '0;
    t_powerup();
    t_latency();
    t_hold();
    t_zero();
    t_one();
    t_minus_one();
    t_extremes();
    t_odd();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule